// File: doc/BRIEF.md
# Compressed Branch Trace Serializer

This block takes the destination address of every program or interrupt branch that the processor core reports and streams it off-chip over a 4-bit trace bus. A sync strobe frames the stream, and a clock-enable output marks every cycle that carries trace content. A trace receiver, clocked by the same peripheral clock, rebuilds the full branch history from this stream.

To save pins and bandwidth, each new destination is compared with the last address that went out in full. Only the low nibbles that differ are sent: 1, 2, 4 or all 8 of them. A header nibble, sent while sync is still high, carries a 2-bit size code so that the receiver knows how many nibbles follow. Address nibbles then go out least significant first, with sync held low.

If a branch arrives while a transfer is running, it is held in a single pending slot. It starts right after the current transfer with no idle gap. If another branch arrives while the slot is occupied, that branch is dropped and a sticky overflow flag records the loss.

Top module: `brtrace_ser`

## Requirements
- R1: With nothing to send, `trc_data` shows 4'b0011, `trc_sync` is 1 and `trc_clk_en` is 0.
- R2: A branch sampled while idle produces, in the next cycle, one header cycle. In that cycle `trc_sync` is 1, `trc_clk_en` is 1 and `trc_data` = {2'b10, code}, where code is a 2-bit size code.
- R3: Code 2'b00 is chosen when bits 31:4 equal the reference. Exactly one nibble follows.
- R4: Code 2'b01 is chosen when bits 31:8 equal the reference and R3 does not apply. Two nibbles follow.
- R5: Code 2'b10 is chosen when bits 31:16 equal the reference and neither R3 nor R4 applies. Four nibbles follow.
- R6: Code 2'b11 is chosen in every other case, including the first branch after reset. Eight nibbles follow.
- R7: Address nibbles follow the header in ascending order (bits 3:0, then 7:4, and so on). `trc_sync` is 0 for exactly as many cycles as there are nibbles, and `trc_clk_en` is 1 in each of those cycles.
- R8: The reference is the whole 32-bit address of the transfer that completed most recently. Dropped branches never become the reference.
- R9: One branch that arrives during a transfer is held. Its header appears in the cycle right after the last nibble of the current transfer.
- R10: A branch that arrives while the pending slot is full and not being freed is dropped and sets `ovf_flag`. The flag stays set until `ovf_clr` is 1 in a cycle with no new drop.
- R11: After reset, `ovf_flag` is 0 and the bus is idle as in R1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock, also the trace clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| br_valid | input | 1 | Pulses for one cycle per taken branch |
| br_addr | input | ADDR_W | Branch destination address |
| ovf_clr | input | 1 | Clears the overflow flag |
| trc_data | output | 4 | Trace nibble bus |
| trc_sync | output | 1 | Low while address nibbles are on the bus |
| trc_clk_en | output | 1 | High on header and address cycles |
| ovf_flag | output | 1 | Sticky overflow indicator |

## Verification
The bench builds the block with the default `ADDR_W` of 32. This lets the chosen addresses land exactly on each compare boundary at bits 4, 8 and 16, and reach the full eight-nibble case. With this width, back-to-back branches can fill the pending slot during a long transfer and then push a third branch into the overflow path. That makes the drop, the sticky flag and the choice of reference after a drop all observable at the ports.

// File: rtl/brt_pkg.sv
package brt_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_HDR, ST_DATA} st_e;

  localparam logic [3:0] IDLE_NIB = 4'b0011;
  localparam logic [1:0] HDR_TAG  = 2'b10;

  // index of the final nibble for each size code
  function automatic logic [3:0] last_idx(input logic [1:0] code);
    case (code)
      2'b00:   last_idx = 4'd0;
      2'b01:   last_idx = 4'd1;
      2'b10:   last_idx = 4'd3;
      default: last_idx = 4'd7;
    endcase
  endfunction
endpackage

// File: rtl/brt_size_sel.sv
module brt_size_sel #(
  parameter int ADDR_W = 32
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [ADDR_W-1:0] ref_addr,
  input  logic              ref_ok,
  output logic [1:0]        code
);
  logic m4, m8, m16;

  always_comb begin
    m4  = ref_ok && (addr[ADDR_W-1:4]  == ref_addr[ADDR_W-1:4]);
    m8  = ref_ok && (addr[ADDR_W-1:8]  == ref_addr[ADDR_W-1:8]);
    m16 = ref_ok && (addr[ADDR_W-1:16] == ref_addr[ADDR_W-1:16]);
    // narrowest match wins
    if (m4)       code = 2'b00;
    else if (m8)  code = 2'b01;
    else if (m16) code = 2'b10;
    else          code = 2'b11;
  end
endmodule

// File: rtl/brt_pend.sv
module brt_pend #(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push,
  input  logic [ADDR_W-1:0] push_addr,
  input  logic              pop,
  input  logic              clr,
  output logic              full,
  output logic [ADDR_W-1:0] addr,
  output logic              ovf
);
  logic              full_d, ovf_d, drop, take;
  logic [ADDR_W-1:0] addr_d;

  always_comb begin
    drop   = push && full && !pop;
    take   = push && (!full || pop);
    full_d = push || (full && !pop);
    addr_d = take ? push_addr : addr;
    ovf_d  = drop ? 1'b1 : (clr ? 1'b0 : ovf);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full <= 1'b0;
      ovf  <= 1'b0;
      addr <= '0;
    end else begin
      full <= full_d;
      ovf  <= ovf_d;
      if (take) addr <= addr_d;
    end
  end

  p_drop_sets_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (push && full && !pop) |=> ovf);
  p_ovf_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf && !clr) |=> ovf);
endmodule

// File: rtl/brtrace_ser.sv
module brtrace_ser
  import brt_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              br_valid,
  input  logic [ADDR_W-1:0] br_addr,
  input  logic              ovf_clr,
  output logic [3:0]        trc_data,
  output logic              trc_sync,
  output logic              trc_clk_en,
  output logic              ovf_flag
);
  localparam int NIB_W = 4;
  localparam int NIBS  = ADDR_W / NIB_W;
  localparam int IDX_W = $clog2(NIBS);

  st_e               st_q, st_d;
  logic [ADDR_W-1:0] cur_q, cur_d, ref_q, ref_d, launch_addr, cmp_ref;
  logic [1:0]        code_q, code_d, sel_code;
  logic [IDX_W-1:0]  idx_q, idx_d;
  logic              refok_q, refok_d, cmp_ok;
  logic              last_nib, launch, direct, pend_push, pend_pop;
  logic              pend_full;
  logic [ADDR_W-1:0] pend_addr;

  always_comb begin
    last_nib    = (st_q == ST_DATA) && (idx_q == IDX_W'(last_idx(code_q)));
    launch      = ((st_q == ST_IDLE) && br_valid) || (last_nib && (pend_full || br_valid));
    direct      = launch && !pend_full;
    launch_addr = pend_full ? pend_addr : br_addr;
    pend_pop    = last_nib && pend_full;
    pend_push   = br_valid && !direct;
    cmp_ref     = last_nib ? cur_q : ref_q;
    cmp_ok      = last_nib || refok_q;
  end

  brt_size_sel #(.ADDR_W(ADDR_W)) u_sel (
    .addr(launch_addr), .ref_addr(cmp_ref), .ref_ok(cmp_ok), .code(sel_code)
  );

  brt_pend #(.ADDR_W(ADDR_W)) u_pend (
    .clk(clk), .rst_n(rst_n), .push(pend_push), .push_addr(br_addr),
    .pop(pend_pop), .clr(ovf_clr), .full(pend_full), .addr(pend_addr),
    .ovf(ovf_flag)
  );

  // next state
  always_comb begin
    st_d    = st_q;
    cur_d   = cur_q;
    code_d  = code_q;
    idx_d   = idx_q;
    ref_d   = ref_q;
    refok_d = refok_q;
    if (last_nib) begin
      ref_d   = cur_q;
      refok_d = 1'b1;
    end
    if (launch) begin
      st_d   = ST_HDR;
      cur_d  = launch_addr;
      code_d = sel_code;
    end else begin
      case (st_q)
        ST_HDR:  begin st_d = ST_DATA; idx_d = '0; end
        ST_DATA: begin
          if (last_nib) st_d = ST_IDLE;
          else          idx_d = idx_q + 1'b1;
        end
        default: st_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      cur_q   <= '0;
      code_q  <= 2'b11;
      idx_q   <= '0;
      ref_q   <= '0;
      refok_q <= 1'b0;
    end else begin
      st_q    <= st_d;
      cur_q   <= cur_d;
      code_q  <= code_d;
      idx_q   <= idx_d;
      ref_q   <= ref_d;
      refok_q <= refok_d;
    end
  end

  // output mux
  always_comb begin
    case (st_q)
      ST_HDR:  trc_data = {HDR_TAG, code_q};
      ST_DATA: trc_data = cur_q[idx_q*NIB_W +: NIB_W];
      default: trc_data = IDLE_NIB;
    endcase
    trc_sync   = (st_q != ST_DATA);
    trc_clk_en = (st_q != ST_IDLE);
  end

  // checker state: length of each sync-low run and the code that announced it
  logic [IDX_W:0] low_run_q;
  logic [1:0]     hdr_code_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      low_run_q  <= '0;
      hdr_code_q <= 2'b11;
    end else begin
      low_run_q <= trc_sync ? '0 : low_run_q + 1'b1;
      if (trc_sync && trc_clk_en) hdr_code_q <= trc_data[1:0];
    end
  end

  p_hdr_first_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(trc_sync) |-> ($past(trc_data[3:2]) == HDR_TAG) && $past(trc_clk_en));
  p_first_full_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_HDR && !refok_q) |-> trc_data[1:0] == 2'b11);
  p_run_len_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(trc_sync) |-> low_run_q == (IDX_W+1)'(last_idx(hdr_code_q)) + 1'b1);
  p_ref_update_r8: assert property (@(posedge clk) disable iff (!rst_n)
    last_nib |=> (ref_q == $past(cur_q)) && refok_q);
  p_gapless_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (last_nib && pend_full) |=> st_q == ST_HDR);
endmodule

// File: tb/brtrace_ser_tb.sv
module brtrace_ser_tb;
  localparam int ADDR_W = 32;

  logic              clk, rst_n, br_valid, ovf_clr;
  logic [ADDR_W-1:0] br_addr;
  logic [3:0]        trc_data;
  logic              trc_sync, trc_clk_en, ovf_flag;

  brtrace_ser #(.ADDR_W(ADDR_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .br_valid(br_valid), .br_addr(br_addr),
    .ovf_clr(ovf_clr), .trc_data(trc_data), .trc_sync(trc_sync),
    .trc_clk_en(trc_clk_en), .ovf_flag(ovf_flag)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  int n_cmp = 0, n_bad = 0;
  logic [4:0] exp_q[$];
  string      tag_q[$];
  logic [ADDR_W-1:0] m_ref;
  logic              m_ok;
  int run_cnt = 0, last_run = 0;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // model: push the expected stream for an accepted branch
  task automatic model_push(input logic [ADDR_W-1:0] a);
    logic [1:0] c;
    int n;
    if (m_ok && a[31:4] == m_ref[31:4])        c = 2'b00;
    else if (m_ok && a[31:8] == m_ref[31:8])   c = 2'b01;
    else if (m_ok && a[31:16] == m_ref[31:16]) c = 2'b10;
    else                                       c = 2'b11;
    n = (c == 2'b00) ? 1 : (c == 2'b01) ? 2 : (c == 2'b10) ? 4 : 8;
    exp_q.push_back({1'b1, 2'b10, c});
    case (c)
      2'b00: tag_q.push_back("R3 header");
      2'b01: tag_q.push_back("R4 header");
      2'b10: tag_q.push_back("R5 header");
      default: tag_q.push_back("R6 header");
    endcase
    for (int i = 0; i < n; i++) begin
      exp_q.push_back({1'b0, a[i*4 +: 4]});
      tag_q.push_back("R7 nibble");
    end
    m_ref = a;
    m_ok  = 1'b1;
  endtask

  task automatic issue(input logic [ADDR_W-1:0] a, input bit accepted);
    @(posedge clk); #1;
    br_valid = 1'b1;
    br_addr  = a;
    if (accepted) model_push(a);
  endtask

  task automatic quiet();
    @(posedge clk); #1;
    br_valid = 1'b0;
  endtask

  task automatic drain();
    while (exp_q.size() != 0) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  task automatic check_idle(input string tag);
    @(negedge clk);
    check(trc_data == 4'b0011 && trc_sync && !trc_clk_en, tag,
          {trc_sync, trc_clk_en, trc_data}, {1'b1, 1'b0, 4'b0011});
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n) begin
      if (trc_clk_en) begin
        run_cnt++;
        if (exp_q.size() == 0) begin
          check(1'b0, "R2 unexpected trace cycle", {trc_sync, trc_data}, 0);
        end else begin
          logic [4:0] e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          check({trc_sync, trc_data} == e, t, {trc_sync, trc_data}, e);
        end
      end else begin
        if (run_cnt != 0) last_run = run_cnt;
        run_cnt = 0;
      end
    end
  end

  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      check(1'b0, "watchdog", cyc, 20000);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; br_valid = 1'b0; br_addr = '0; ovf_clr = 1'b0;
    m_ref = '0; m_ok = 1'b0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    check(!ovf_flag, "R11 overflow after reset", ovf_flag, 0);
    check_idle("R11 R1 idle after reset");

    // first branch is full (R6), then the narrower codes
    issue(32'h1234_5678, 1); quiet(); drain();
    issue(32'h1234_567A, 1); quiet(); drain();   // R3
    issue(32'h1234_56F0, 1); quiet(); drain();   // R4
    issue(32'h1234_ABCD, 1); quiet(); drain();   // R5
    issue(32'hFFFF_0000, 1); quiet(); drain();   // R6
    issue(32'hFFFF_0000, 1); quiet(); drain();   // identical -> R3
    check_idle("R1 idle between branches");

    // R9: back-to-back, second held and sent with no gap
    issue(32'hFFFF_0003, 1); issue(32'hFFFF_0013, 1); quiet(); drain();
    check(last_run == 5, "R9 gapless pending run", last_run, 5);

    // R10: third branch dropped while slot full
    issue(32'h8000_0000, 1); issue(32'h8000_0001, 1); issue(32'h0BAD_0BAD, 0); quiet();
    @(negedge clk);
    check(ovf_flag, "R10 overflow set on drop", ovf_flag, 1);
    drain();
    check(ovf_flag, "R10 overflow sticky", ovf_flag, 1);
    @(posedge clk); #1 ovf_clr = 1'b1;
    @(posedge clk); #1 ovf_clr = 1'b0;
    @(negedge clk);
    check(!ovf_flag, "R10 overflow cleared", ovf_flag, 0);

    // R8: reference is the last completed address, not the dropped one
    issue(32'h8000_0005, 1); quiet(); drain();
    check(last_run == 2, "R8 reference after drop", last_run, 2);
    check_idle("R1 idle at end");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule